// File: doc/BRIEF.md
# Multichannel PCM Time-Slot Port

This block is the serial side of a four-channel voice port. All channels share one bit clock and one frame sync. The frame is a fixed number of eight-bit slots. Each channel has its own programmable slot for sending and its own for receiving, and the two are set independently. During its transmit slot a channel's word goes out on the single transmit line, most significant bit first, and a per-bit output enable marks every bit that is driven. At all other times the enable is low, so the pad around the block can leave the line floating. In the same way, each channel collects its receive word bit by bit from the single receive line during its own receive slot. When the word is complete, it appears in parallel with a one-cycle valid strobe.

Bits are launched on the rising edge of the bit clock and sampled on the falling edge. A channel that is powered down neither drives nor captures. In the wide (linear) coding mode every channel uses sixteen bits, which is its programmed slot and the slot after it. When two channels are given the same transmit slot, the lower-numbered channel is the one sent. Slot numbers at or past the frame length never match.

Top module: `pcm_slot_port`

## Requirements
- R1: `txOe` is low, and `txLine` is 0, in every bit period that is not inside the transmit window of a channel that is not powered down. This includes every bit before the first frame sync.
- R2: A rising edge with `frameSync` high launches bit 0 of slot 0. Each later rising edge advances the bit position by one. After bit FRAME_SLOTS*8-1 the position wraps to 0 with or without a sync, and a sync in mid-frame restarts the position at 0.
- R3: Channel c's transmit window begins at bit position 8*slot, where slot is field c (bits c*SLOT_W upward) of `txSlot`. The window is 8 bits long in byte mode and 16 bits long when `linearMode` is 1. Bit k of the window carries word bit W-1-k of `txData[c*16 +: 16]`, where W is 8 or 16. Byte mode therefore sends bits 7..0.
- R4: A channel whose `powerDown` bit is 1 drives nothing in its transmit window and captures nothing in its receive window.
- R5: When the transmit windows of several active channels cover the same bit, the lowest-numbered of those channels supplies the bit.
- R6: A slot number at or beyond FRAME_SLOTS never matches. A 16-bit window that starts in the last slot is cut off at the end of the frame, and its receive word never completes.
- R7: `rxLine` is sampled on the falling edge, and the first sampled bit is the most significant. A completed byte-mode word appears in `rxData[c*16 +: 16]` with its upper byte zero.
- R8: `rxValid[c]` is high for exactly one clock cycle, starting at the rising edge after the last bit of the window is sampled. `rxData` for channel c changes only on that edge.
- R9: While `rst_n` is low, `txOe`, `txLine`, `rxValid` and `rxData` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frameSync | input | 1 | Frame start, sampled on the rising edge |
| txSlot | input | NUM_CH*SLOT_W | Transmit slot number per channel |
| rxSlot | input | NUM_CH*SLOT_W | Receive slot number per channel |
| powerDown | input | NUM_CH | Per-channel power-down |
| linearMode | input | 1 | 1: 16-bit words over two slots; 0: 8-bit words |
| txData | input | NUM_CH*16 | Parallel transmit word per channel |
| rxLine | input | 1 | Serial receive line |
| txLine | output | 1 | Serial transmit data |
| txOe | output | 1 | Drive enable for txLine |
| rxData | output | NUM_CH*16 | Last completed receive word per channel |
| rxValid | output | NUM_CH | One-cycle strobe per completed receive word |

## Verification
The hardest conditions to reach from the ports are windows that do not follow the normal frame rhythm. These are a 16-bit window truncated by the frame end, a frame that wraps with no sync, and a sync that arrives mid-frame and cuts a word short. The stimulus places a linear-mode channel in the last slot, stops sending syncs for several frames, and then sends syncs at an interval shorter than the frame. The behavioural model follows the position through each of these cases. Slot overlaps and power-down patterns are applied while random serial data is on the receive line, so the receive shifters always hold data that is not trivial.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;
  // transmit strobes handed from control to datapath each bit period
  typedef struct packed {
    logic       txDrive;  // a channel owns the next bit
    logic [3:0] txCh;     // owning channel
    logic [3:0] txBit;    // word bit index to launch
  } txStrobe_t;
endpackage

// File: rtl/pcm_slot_ctrl.sv
module pcm_slot_ctrl
  import pcm_slot_pkg::*;
#(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned FRAME_SLOTS = 32,
  parameter int unsigned SLOT_W      = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frameSync,
  input  logic [NUM_CH*SLOT_W-1:0] txSlot,
  input  logic [NUM_CH*SLOT_W-1:0] rxSlot,
  input  logic [NUM_CH-1:0]        powerDown,
  input  logic                     linearMode,
  output txStrobe_t                txStb,
  output logic [NUM_CH-1:0]        rxTake,
  output logic [NUM_CH-1:0]        rxLast
);
  localparam int unsigned TOT_BITS = FRAME_SLOTS * 8;
  localparam int unsigned POS_W    = $clog2(TOT_BITS);

  logic [POS_W-1:0] pos, posNext;
  logic             synced, syncedNext;

  always_comb begin
    syncedNext = synced | frameSync;
    if (frameSync)                       posNext = '0;
    else if (pos == POS_W'(TOT_BITS - 1)) posNext = '0;
    else                                  posNext = pos + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= '0;
      synced <= 1'b0;
    end else begin
      if (syncedNext) pos <= posNext;
      synced <= syncedNext;
    end
  end

  // transmit ownership for the bit launched at the coming edge
  always_comb begin
    int slotNum, relPos, wid;
    txStb = '0;
    wid   = linearMode ? 16 : 8;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      slotNum = int'(txSlot[c*SLOT_W +: SLOT_W]);
      relPos  = int'(posNext) - slotNum * 8;
      if (syncedNext && !powerDown[c] && slotNum < int'(FRAME_SLOTS) &&
          relPos >= 0 && relPos < wid) begin
        txStb.txDrive = 1'b1;
        txStb.txCh    = 4'(c);
        txStb.txBit   = 4'(wid - 1 - relPos);
      end
    end
  end

  // receive windows for the bit currently on the line
  always_comb begin
    int slotNum, relPos, wid;
    rxTake = '0;
    rxLast = '0;
    wid    = linearMode ? 16 : 8;
    for (int c = 0; c < NUM_CH; c++) begin
      slotNum = int'(rxSlot[c*SLOT_W +: SLOT_W]);
      relPos  = int'(pos) - slotNum * 8;
      if (synced && !powerDown[c] && slotNum < int'(FRAME_SLOTS) &&
          relPos >= 0 && relPos < wid) begin
        rxTake[c] = 1'b1;
        rxLast[c] = (relPos == wid - 1);
      end
    end
  end
endmodule

// File: rtl/pcm_slot_dp.sv
module pcm_slot_dp
  import pcm_slot_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  txStrobe_t            txStb,
  input  logic [NUM_CH-1:0]    rxTake,
  input  logic [NUM_CH-1:0]    rxLast,
  input  logic                 linearMode,
  input  logic [NUM_CH*16-1:0] txData,
  input  logic                 rxLine,
  output logic                 txLine,
  output logic                 txOe,
  output logic [NUM_CH*16-1:0] rxData,
  output logic [NUM_CH-1:0]    rxValid
);
  logic [15:0] txWord;

  always_comb begin
    txWord = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (txStb.txCh == 4'(c)) txWord = txData[c*16 +: 16];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txOe   <= 1'b0;
      txLine <= 1'b0;
    end else begin
      txOe   <= txStb.txDrive;
      txLine <= txStb.txDrive & txWord[txStb.txBit];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_rx
    logic [15:0] shiftReg, captWord;
    logic        doneFlag;

    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shiftReg <= '0;
        captWord <= '0;
        doneFlag <= 1'b0;
      end else begin
        doneFlag <= rxTake[c] & rxLast[c];
        if (rxTake[c]) begin
          shiftReg <= {shiftReg[14:0], rxLine};
          if (rxLast[c])
            captWord <= linearMode ? {shiftReg[14:0], rxLine}
                                   : {8'h00, shiftReg[6:0], rxLine};
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rxValid[c]          <= 1'b0;
        rxData[c*16 +: 16]  <= '0;
      end else begin
        rxValid[c] <= doneFlag;
        if (doneFlag) rxData[c*16 +: 16] <= captWord;
      end
    end
  end
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
  import pcm_slot_pkg::*;
#(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned FRAME_SLOTS = 32,
  parameter int unsigned SLOT_W      = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frameSync,
  input  logic [NUM_CH*SLOT_W-1:0] txSlot,
  input  logic [NUM_CH*SLOT_W-1:0] rxSlot,
  input  logic [NUM_CH-1:0]        powerDown,
  input  logic                     linearMode,
  input  logic [NUM_CH*16-1:0]     txData,
  input  logic                     rxLine,
  output logic                     txLine,
  output logic                     txOe,
  output logic [NUM_CH*16-1:0]     rxData,
  output logic [NUM_CH-1:0]        rxValid
);
  txStrobe_t         txStb;
  logic [NUM_CH-1:0] rxTake, rxLast;

  pcm_slot_ctrl #(.NUM_CH(NUM_CH), .FRAME_SLOTS(FRAME_SLOTS), .SLOT_W(SLOT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frameSync(frameSync), .txSlot(txSlot), .rxSlot(rxSlot),
    .powerDown(powerDown), .linearMode(linearMode), .txStb(txStb),
    .rxTake(rxTake), .rxLast(rxLast)
  );

  pcm_slot_dp #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rst_n(rst_n), .txStb(txStb), .rxTake(rxTake), .rxLast(rxLast),
    .linearMode(linearMode), .txData(txData), .rxLine(rxLine), .txLine(txLine),
    .txOe(txOe), .rxData(rxData), .rxValid(rxValid)
  );
endmodule

// File: rtl/pcm_slot_port_chk.sv
module pcm_slot_port_chk #(
  parameter int unsigned NUM_CH = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 txLine,
  input logic                 txOe,
  input logic [NUM_CH-1:0]    powerDown,
  input logic [NUM_CH*16-1:0] rxData,
  input logic [NUM_CH-1:0]    rxValid
);
  AST_QUIET_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !txOe |-> !txLine); // R1

  AST_DRIVE_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    txOe |-> !(&$past(powerDown))); // R4

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rxValid[c] |=> !rxValid[c]); // R8

    AST_RXDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rxData[c*16 +: 16]) |-> rxValid[c]); // R8
  end
endmodule

bind pcm_slot_port pcm_slot_port_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .txLine(txLine), .txOe(txOe),
  .powerDown(powerDown), .rxData(rxData), .rxValid(rxValid)
);

// File: tb/tb_pcm_slot_port.sv
module tb_pcm_slot_port;
  localparam int NCH = 4;
  localparam int FSL = 8;
  localparam int SW  = 8;
  localparam int TOT = FSL * 8;

  logic clk = 1'b0, rst_n = 1'b0, frameSync = 1'b0, linearMode = 1'b0, rxLine = 1'b0;
  logic [NCH*SW-1:0] txSlot = '0, rxSlot = '0;
  logic [NCH-1:0]    powerDown = '0;
  logic [NCH*16-1:0] txData = '0;
  logic txLine, txOe;
  logic [NCH*16-1:0] rxData;
  logic [NCH-1:0]    rxValid;

  int total = 0, bad = 0;
  bit finished = 0;
  string tag = "R1";

  // behavioural model state
  int  mPos = 0;
  bit  mSync = 0;
  logic [15:0] mShift [NCH];
  logic [15:0] mData  [NCH];
  logic [15:0] pendData [NCH];
  bit  pend [NCH];
  logic [NCH-1:0] mValid;

  pcm_slot_port #(.NUM_CH(NCH), .FRAME_SLOTS(FSL), .SLOT_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .frameSync(frameSync), .txSlot(txSlot), .rxSlot(rxSlot),
    .powerDown(powerDown), .linearMode(linearMode), .txData(txData), .rxLine(rxLine),
    .txLine(txLine), .txOe(txOe), .rxData(rxData), .rxValid(rxValid)
  );

  always #4 clk = ~clk;

  function automatic bit inWin(int p, int slot, output int rel);
    int wid = linearMode ? 16 : 8;
    rel = p - slot * 8;
    return slot < FSL && rel >= 0 && rel < wid;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h @%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    int rel, wid;
    bit expOe, expLine;
    logic [NCH*16-1:0] expData;
    wid = linearMode ? 16 : 8;
    // receive sample at the coming falling edge (R7)
    rxLine = 1'($urandom);
    for (int c = 0; c < NCH; c++) begin
      pend[c] = 0;
      if (mSync && !powerDown[c] && inWin(mPos, int'(rxSlot[c*SW +: SW]), rel)) begin
        mShift[c] = {mShift[c][14:0], rxLine};
        if (rel == wid - 1) begin
          pend[c] = 1;
          pendData[c] = linearMode ? mShift[c] : {8'h00, mShift[c][7:0]};
        end
      end
    end
    @(posedge clk);
    // position (R2)
    if (frameSync) begin mPos = 0; mSync = 1; end
    else if (mSync) mPos = (mPos + 1) % TOT;
    expOe = 0; expLine = 0;
    if (mSync)
      for (int c = 0; c < NCH; c++)
        if (!expOe && !powerDown[c] && inWin(mPos, int'(txSlot[c*SW +: SW]), rel)) begin
          expOe = 1;
          expLine = txData[c*16 + (wid - 1 - rel)];
        end
    for (int c = 0; c < NCH; c++) begin
      mValid[c] = pend[c];
      if (pend[c]) mData[c] = pendData[c];
      expData[c*16 +: 16] = mData[c];
    end
    #2;
    check(txOe == expOe, expOe ? tag : "R1", "txOe", txOe, expOe);
    check(txLine == expLine, expOe ? tag : "R1", "txLine", txLine, expLine);
    check(rxValid == mValid, "R8", "rxValid", rxValid, mValid);
    check(rxData == expData, "R7", "rxData", rxData, expData);
    #1;
  endtask

  task automatic run(int n, int syncEvery);
    for (int i = 0; i < n; i++) begin
      frameSync = (syncEvery > 0) && (i % syncEvery == 0);
      step();
    end
    frameSync = 1'b0;
  endtask

  task automatic setSlots(int t0, int t1, int t2, int t3, int r0, int r1, int r2, int r3);
    txSlot = {SW'(t3), SW'(t2), SW'(t1), SW'(t0)};
    rxSlot = {SW'(r3), SW'(r2), SW'(r1), SW'(r0)};
    txData = {16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom)};
  endtask

  initial begin
    #(150000 * 8);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin mShift[c] = '0; mData[c] = '0; pend[c] = 0; end
    setSlots(1, 3, 5, 7, 2, 0, 6, 4);
    rxLine = 1'b1;
    #20;
    // R9 reset state
    check(txOe == 0 && txLine == 0, "R9", "tx at reset", {txOe, txLine}, 0);
    check(rxValid == 0, "R9", "rxValid at reset", rxValid, 0);
    check(rxData == 0, "R9", "rxData at reset", rxData, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    tag = "R1"; run(12, 0);                       // R1 quiet before first sync
    tag = "R3"; run(200, TOT);                    // R3 byte mode
    linearMode = 1'b1;
    setSlots(0, 2, 4, 6, 6, 4, 2, 0);
    tag = "R3"; run(200, TOT);                    // R3 linear mode
    linearMode = 1'b0;
    setSlots(3, 3, 1, 3, 3, 3, 5, 5);
    tag = "R5"; run(140, TOT);                    // R5 overlap priority
    powerDown = 4'b0101;
    setSlots(0, 1, 2, 3, 0, 1, 2, 3);
    tag = "R4"; run(140, TOT);                    // R4 power-down
    powerDown = 4'b0000;
    linearMode = 1'b1;
    setSlots(8, 7, 200, 2, 7, 9, 1, 3);
    tag = "R6"; run(140, TOT);                    // R6 out of range / cut window
    linearMode = 1'b0;
    setSlots(0, 2, 5, 7, 1, 3, 4, 6);
    tag = "R2"; run(1, 0 + 1); run(200, 0);       // R2 wrap without sync
    tag = "R2"; run(150, 37);                     // R2 early resync
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule